// File: doc/BRIEF.md
# Masked-Write Two-Pin GPIO Control Register

This block is a single memory-mapped control word that drives two bidirectional pads for a software-driven serial bus such as I2C or a display data channel. Pin 0 is the clock line and pin 1 the data line. Each pin keeps two stored bits: a direction (output enable) and an output level. These bits reach the pad driver directly.

A write to the register carries a separate write-enable mask bit next to each stored bit. A stored bit changes only when its own mask bit is set in the same word. Software can therefore drive the clock, release the data line or turn a pin around with one write, without reading the register first. A read returns the stored direction and level of each pin. It also returns the level seen at each pad, after a two-flop synchroniser, whatever the pin's direction. Software polls this level to see clock stretching and acknowledge bits.

The register bus is a plain slave with an address, a write strobe, write data and combinational read data. The register answers at one parameterised address.

Top module: `gpio_pair_reg`

## Requirements
- R1: After a synchronous active-low reset, both pins are inputs (`pad_oe` = 0) with stored level 0 (`pad_out` = 0). A read returns 0 in bits 1, 3, 9 and 11.
- R2: A write to the register address with bit 2 (pin 0) or bit 10 (pin 1) set loads that pin's stored level from bit 3 or bit 11 respectively. The new level appears on `pad_out` in the cycle after the write edge.
- R3: A write with a pin's level-mask bit (bit 2 or bit 10) clear leaves that pin's stored level unchanged, whatever the level bit carries.
- R4: A write with bit 0 (pin 0) or bit 8 (pin 1) set loads that pin's direction from bit 1 or bit 9. Direction 1 makes the pin an output (`pad_oe` = 1); direction 0 makes it an input.
- R5: A write with a pin's direction-mask bit (bit 0 or bit 8) clear leaves that pin's direction unchanged.
- R6: Pin 0 is controlled only by bits [4:0] and pin 1 only by bits [12:8]. A write that updates one pin never alters the other. Direction and level of one pin may both be updated by the same write.
- R7: A read of the register address returns the stored direction in bits 1 and 9 and the stored level in bits 3 and 11. Bits 4 and 12 carry the pad level of pin 0 and pin 1, delayed by two clock edges, for either direction. Every other bit (the masks and bits [7:5], [31:13]) reads as 0.
- R8: Writes to any other address have no effect. Reads of any other address return 0.
- R9: When a read and a write to the register fall in the same cycle, the read data shows the state from before the write. The written state appears from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and synchroniser clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register bus address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data with mask and value fields |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | 2 | Pad levels; bit 0 clock pin, bit 1 data pin |
| pad_oe | output | 2 | Pad output enables (1 = drive) |
| pad_out | output | 2 | Pad output levels |

## Verification
Two functions of this block can fall in the same cycle. A read can meet a masked write, and a pad input edge can arrive while a write retargets the pin's direction. The bench drives a write and a read of the same address in one cycle while it also toggles `pad_in`. It then judges the read data on both sides of the write edge: the stored fields must show the old state, then the new one, and the input bits must follow the pad two edges late, untouched by the write. A behavioural per-cycle model compares every output on each clock. Directed writes also mix masked and unmasked fields across both pins in one word.

// File: rtl/gpio_pair_pkg.sv
// Package: shared field layout and state type for the two-pin GPIO register.
// Assumes each pin owns a 5-bit field and fields repeat every PIN_STRIDE bits.
package gpio_pair_pkg;
    localparam int DATA_W     = 32;
    localparam int NUM_PINS   = 2;
    localparam int PIN_STRIDE = 8;
    localparam int FIELD_W    = 5;
    // bit offsets inside one pin field
    localparam int DIR_MSK    = 0;
    localparam int DIR_VAL    = 1;
    localparam int LVL_MSK    = 2;
    localparam int LVL_VAL    = 3;
    localparam int PAD_LVL    = 4;
    // bits of a field consumed by the write path
    localparam int CTRL_W     = 4;

    typedef struct packed {
        logic drive;   // 1 = output
        logic level;   // stored output level
    } pin_state_t;
endpackage

// File: rtl/gpio_pair_sync.sv
// Module: gpio_pair_sync
// Two-flop synchroniser for WIDTH asynchronous pad inputs.
// Assumes inputs are independent single-bit levels (no bus coherency needed).
module gpio_pair_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    // Capture pad levels through two flops, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;

    // R7
    sync_second_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stable_q == $past(meta_q));
endmodule

// File: rtl/gpio_pair_pin.sv
// Module: gpio_pair_pin
// Stored direction and level of one pin, each updated only under its mask bit.
// Assumes ctrl_i is the pin's field from the bus word and wr_hit qualifies it.
module gpio_pair_pin
    import gpio_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [CTRL_W-1:0] ctrl_i,
    output pin_state_t        state_o
);
    pin_state_t state_q;

    // Masked update of direction and level; reset to input, level 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (wr_hit) begin
            if (ctrl_i[DIR_MSK]) state_q.drive <= ctrl_i[DIR_VAL];
            if (ctrl_i[LVL_MSK]) state_q.level <= ctrl_i[LVL_VAL];
        end
    end

    assign state_o = state_q;

    // R2
    level_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && ctrl_i[LVL_MSK]) |=> (state_o.level == $past(ctrl_i[LVL_VAL])));
    // R3
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && ctrl_i[LVL_MSK]) |=> $stable(state_o.level));
    // R4
    drive_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && ctrl_i[DIR_MSK]) |=> (state_o.drive == $past(ctrl_i[DIR_VAL])));
    // R5
    drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && ctrl_i[DIR_MSK]) |=> $stable(state_o.drive));
endmodule

// File: rtl/gpio_pair_reg.sv
// Module: gpio_pair_reg (top)
// Bus slave for one masked-write GPIO control word driving a clock and data pin.
// Assumes a single-cycle write strobe and combinational read of bus_addr.
module gpio_pair_reg
    import gpio_pair_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out
);
    localparam int USED_W = (NUM_PINS - 1) * PIN_STRIDE + FIELD_W;

    logic                addr_hit;
    logic                wr_hit;
    logic [NUM_PINS-1:0] pad_sync;
    pin_state_t          pin_state [NUM_PINS];
    logic [DATA_W-1:0]   read_word;
    logic                unused_wbits;

    assign addr_hit = (bus_addr == REG_ADDR);
    assign wr_hit   = bus_wr && addr_hit;

    gpio_pair_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (pad_sync)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpio_pair_pin u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_hit),
            .ctrl_i  (bus_wdata[p*PIN_STRIDE +: CTRL_W]),
            .state_o (pin_state[p])
        );
        assign pad_oe[p]  = pin_state[p].drive;
        assign pad_out[p] = pin_state[p].level;
    end

    // Assemble the read word: stored bits, synchronised pad level, zeros elsewhere.
    always_comb begin
        read_word = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            read_word[p*PIN_STRIDE + DIR_VAL] = pin_state[p].drive;
            read_word[p*PIN_STRIDE + LVL_VAL] = pin_state[p].level;
            read_word[p*PIN_STRIDE + PAD_LVL] = pad_sync[p];
        end
    end

    // Return the word only for the register address.
    assign bus_rdata = addr_hit ? read_word : '0;

    // Reserved and mask write bits intentionally have no storage.
    assign unused_wbits = ^bus_wdata[DATA_W-1:USED_W];

    // R8
    other_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_hit |-> (bus_rdata == '0));
    // R7
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit |-> (bus_rdata[DIR_VAL] == pad_oe[0]
                      && bus_rdata[PIN_STRIDE + DIR_VAL] == pad_oe[1]));
    // R8
    no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> ($stable(pad_oe) && $stable(pad_out)));
endmodule

// File: tb/gpio_pair_reg_tb.sv
// Bench: behavioural per-cycle model of the GPIO word, compared on every clock.
module gpio_pair_reg_tb;
    localparam logic [7:0] REG = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [1:0]  pad_in = 2'b00;
    logic [1:0]  pad_oe;
    logic [1:0]  pad_out;

    int    checks = 0;
    int    fails = 0;
    int    cycles = 0;
    bit    done = 0;
    bit    model_live = 0;
    string cur_req = "R1";

    // behavioural model state
    bit       m_drive [2];
    bit       m_level [2];
    bit [1:0] pad_hist [$];

    always #2.5 clk = ~clk;

    gpio_pair_reg u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    // Model update at each rising edge.
    always @(posedge clk) begin
        model_live <= 1'b1;
        if (!rst_n) begin
            for (int p = 0; p < 2; p++) begin m_drive[p] = 0; m_level[p] = 0; end
            pad_hist = '{2'b00, 2'b00};
        end else begin
            if (bus_wr && bus_addr == REG) begin
                for (int p = 0; p < 2; p++) begin
                    if (bus_wdata[p*8 + 0]) m_drive[p] = bus_wdata[p*8 + 1];
                    if (bus_wdata[p*8 + 2]) m_level[p] = bus_wdata[p*8 + 3];
                end
            end
            pad_hist.push_back(pad_in);
            void'(pad_hist.pop_front());
        end
    end

    function automatic logic [31:0] exp_rdata();
        logic [31:0] w = '0;
        if (bus_addr != REG) return '0;
        for (int p = 0; p < 2; p++) begin
            w[p*8 + 1] = m_drive[p];
            w[p*8 + 3] = m_level[p];
            w[p*8 + 4] = pad_hist[0][p];
        end
        return w;
    endfunction

    task automatic check32(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        if (!model_live) return;
        check32("pad_oe", {30'h0, pad_oe}, {30'h0, m_drive[1], m_drive[0]});
        check32("pad_out", {30'h0, pad_out}, {30'h0, m_level[1], m_level[0]});
        check32("bus_rdata", bus_rdata, exp_rdata());
    endtask

    task automatic step();
        @(negedge clk);
        compare();
    endtask

    task automatic drive(logic wr, logic [7:0] a, logic [31:0] d);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        #1 compare();
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        step();
        drive(1'b1, a, d);
        step();
        drive(1'b0, REG, 32'h0);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        // R1 reset state
        cur_req = "R1";
        repeat (3) step();
        drive(1'b0, REG, 32'h0);
        rst_n = 1'b1;
        repeat (2) step();
        // R2 level loads under mask, each pin
        cur_req = "R2";
        wr(REG, 32'h0000_000C);
        wr(REG, 32'h0000_0C00);
        wr(REG, 32'h0000_0004);
        // R3 level bits without mask are ignored
        cur_req = "R3";
        wr(REG, 32'h0000_0808);
        wr(REG, 32'h0000_0800);
        // R4 direction loads
        cur_req = "R4";
        wr(REG, 32'h0000_0303);
        // R5 direction held without mask, then released
        cur_req = "R5";
        wr(REG, 32'h0000_0000);
        wr(REG, 32'h0000_0101);
        // R6 one pin only, both fields of one pin in one word
        cur_req = "R6";
        wr(REG, 32'h0000_000F);
        wr(REG, 32'h0000_0F00);
        wr(REG, 32'h0000_0004);
        // R7 reserved bits written high, pad levels seen two edges late
        cur_req = "R7";
        wr(REG, 32'hFFFF_E0E0);
        step(); pad_in = 2'b01;
        step(); pad_in = 2'b10;
        step(); pad_in = 2'b11;
        repeat (3) step();
        pad_in = 2'b00;
        repeat (3) step();
        // R8 other address: no write effect, read returns 0
        cur_req = "R8";
        wr(8'h14, 32'h0000_0F0F);
        step(); drive(1'b0, 8'h11, 32'h0);
        step(); drive(1'b0, REG, 32'h0);
        // R9 read and write same cycle, with a pad edge in the same cycle
        cur_req = "R9";
        step();
        pad_in = 2'b11;
        drive(1'b1, REG, 32'h0000_0F0F);
        step();
        drive(1'b1, REG, 32'h0000_0505);
        step();
        drive(1'b0, REG, 32'h0);
        repeat (3) step();
        // R6 and R7 mixed pseudo-random traffic
        cur_req = "R6";
        for (int i = 0; i < 300; i++) begin
            step();
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pad_in = lfsr[1:0];
            drive(lfsr[2], lfsr[3] ? REG : 8'h20, {lfsr[7:4], lfsr[15:4], lfsr[11:4], lfsr[15:8]});
        end
        step();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule